// File: doc/BRIEF.md
# Dual-Channel Output-Compare Timer

Two independent 16-bit up-counters, each with four compare registers (A, B, C, D), are controlled through a byte-wide register port. While its channel runs, a counter advances once per clock. When the counter reaches register A, the counter returns to zero and the channel raises a one-cycle compare pulse. A per-channel select decides what the channel does at that point. It either halts and drops its run flag, or it keeps counting, which gives a period of A+1 cycles.

Registers C and D can each serve as further compare registers, or they can act as staging buffers. A buffer's value moves into A (from C) or into B (from D) at the next A match, so a new period or duty point takes effect cleanly on a period boundary. A synchronous mode ties the two channels together. In that mode they start and stop together, and an A match on either channel zeroes both counters in the same cycle.

The register port is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `dual_oc_timer`

## Requirements
- R1: After reset the control byte (address 0x00) reads 0xFC, the mode byte (0x01) reads 0x0E, both counters read 0, and every A/B/C/D byte reads 0xFF.
- R2: Control byte layout: bit 0 and bit 1 are the run flags of channel 0 and channel 1; bits 2 and 3 are their continue selects. Bits 7:4 always read 1 and ignore writes. Mode byte layout: bit 0 is sync; bits 3:1 always read 1; bits 4, 5, 6, 7 make C0, D0, C1, D1 buffers (1) or general compare registers (0).
- R3: A channel whose run flag is set increments its counter by one per clock. A stopped counter holds its value.
- R4: When a running counter equals its A register at a clock edge, the counter becomes 0 on that edge and `cmp_ac` of that channel is high for exactly the following cycle.
- R5: With the continue select at 0, that A match also clears the channel's run flag, so the counter stays at 0.
- R6: With the continue select at 1, the channel keeps counting, and A matches recur every A+1 cycles.
- R7: A control-byte write that sets a run flag in the same cycle as a hardware clear of that flag leaves the flag cleared.
- R8: When C (or D) is in buffer mode, its value is copied into A (or B) of the same channel at that channel's A match.
- R9: A running counter equal to B pulses `cmp_bd`. A general-mode C pulses `cmp_ac`, and a general-mode D pulses `cmp_bd`, each one cycle after the match edge. A buffer-mode C or D produces no pulse.
- R10: In sync mode a control write sets both run flags to the OR of bits 1:0. An A match on either channel zeroes both counters. A stop from either channel clears both run flags.
- R11: The channel registers are byte addressed: channel n (0 or 1) at 0x10*(n+1). Offsets 0/1 are the counter low/high bytes and are read-only. Offsets 2/3, 4/5, 6/7 and 8/9 hold A, B, C and D, low byte first. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cmp_ac | output | 2 | Per-channel pulse for A match or general-mode C match |
| cmp_bd | output | 2 | Per-channel pulse for B match or general-mode D match |

## Verification
A wrong run flag or continue select shows up in the control byte readback on the next read. A counter off by one shifts the compare pulse by a whole cycle and changes the measured period. The bench counts cycles from the start write to each pulse, so such faults are caught at the first match. A buffer transfer that is missing or misrouted is not visible until the next A match, when the A or B readback and the following period disagree. A sync fault appears at the first match, as a nonzero counter on the partner channel.

// File: rtl/dual_oc_pkg.sv
package dual_oc_pkg;
  localparam int NCH = 2;
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_MODE = 8'h01;
  localparam logic [7:0] CTRL_RST  = 8'hFC;
  localparam logic [7:0] MODE_RST  = 8'h0E;
  localparam logic [2:0] SEL_CNT = 3'd0;
  localparam logic [2:0] SEL_A   = 3'd1;
  localparam logic [2:0] SEL_B   = 3'd2;
  localparam logic [2:0] SEL_C   = 3'd3;
  localparam logic [2:0] SEL_D   = 3'd4;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import dual_oc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           wr_mode,
  input  logic [7:0]     wdata,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] run_eff,
  output logic [NCH-1:0] cont,
  output logic [NCH-1:0] bf_c,
  output logic [NCH-1:0] bf_d,
  output logic           sync,
  output logic [7:0]     ctrl_q,
  output logic [7:0]     mode_q
);
  logic [NCH-1:0] run;
  logic [3:0]     bf;
  logic [NCH-1:0] stop_req;
  logic           stop_any;

  assign stop_req = hit & ~cont;
  assign stop_any = |stop_req;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_run
      always_ff @(posedge clk) begin
        if (!rst_n)
          run[c] <= 1'b0;
        else if (sync ? stop_any : stop_req[c])
          run[c] <= 1'b0;
        else if (wr_ctrl)
          run[c] <= sync ? (|wdata[NCH-1:0]) : wdata[c];
      end

      assert_hw_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req[c] |=> !run[c]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cont <= CTRL_RST[3:2];
      sync <= MODE_RST[0];
      bf   <= MODE_RST[7:4];
    end else begin
      if (wr_ctrl) cont <= wdata[3:2];
      if (wr_mode) begin
        sync <= wdata[0];
        bf   <= wdata[7:4];
      end
    end
  end

  assign bf_c    = {bf[2], bf[0]};
  assign bf_d    = {bf[3], bf[1]};
  assign ctrl_q  = {4'hF, cont, run};
  assign mode_q  = {bf, 3'b111, sync};
  assign run_eff = sync ? {NCH{|run}} : run;

  assert_sync_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && wr_ctrl && !$past(!rst_n)) |=> (run[0] == run[1]));
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import dual_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  peer_clr,
  input  logic                  bf_c,
  input  logic                  bf_d,
  input  logic                  wr_en,
  input  logic [2:0]            sel,
  input  logic [$clog2(CNT_W/8)-1:0] lane,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  hit,
  output logic [CNT_W-1:0]      cnt,
  output logic                  cmp_ac,
  output logic                  cmp_bd
);
  localparam int NREG   = 4;
  localparam int LANE_W = $clog2(CNT_W/8);

  logic [NREG-1:0][CNT_W-1:0] gr;
  logic [NREG-1:0]            m;
  logic [NREG-1:0]            wr_hit;
  logic [1:0]                 bf;

  assign bf = {bf_d, bf_c};

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      assign wr_hit[i] = wr_en && (sel == 3'(i + 1));
      assign m[i]      = run && (cnt == gr[i]);

      always_ff @(posedge clk) begin
        if (!rst_n)
          gr[i] <= '1;
        else if (wr_hit[i])
          gr[i][{lane, 3'b000} +: 8] <= wdata;
        else if (i < 2 && hit && bf[i % 2])
          gr[i] <= gr[(i + 2) % NREG];
      end

      if (i < 2) begin : g_buf_chk
        assert_buffer_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
          (hit && bf[i] && !wr_hit[i]) |=> (gr[i] == $past(gr[i + 2])));
      end
    end
  endgenerate

  assign hit = m[0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (hit || peer_clr)
      cnt <= '0;
    else if (run)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_ac <= 1'b0;
      cmp_bd <= 1'b0;
    end else begin
      cmp_ac <= m[0] | (m[2] & ~bf_c);
      cmp_bd <= m[1] | (m[3] & ~bf_d);
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (sel)
      SEL_CNT: rdata = cnt[{lane, 3'b000} +: 8];
      SEL_A:   rdata = gr[0][{lane, 3'b000} +: 8];
      SEL_B:   rdata = gr[1][{lane, 3'b000} +: 8];
      SEL_C:   rdata = gr[2][{lane, 3'b000} +: 8];
      SEL_D:   rdata = gr[3][{lane, 3'b000} +: 8];
      default: rdata = 8'h00;
    endcase
  end

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
  assert_match_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp_ac);
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !peer_clr && !$past(!rst_n)) |=> $stable(cnt));
  assert_b_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m[1] |=> cmp_bd);
endmodule

// File: rtl/dual_oc_timer.sv
module dual_oc_timer
  import dual_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [1:0] cmp_ac,
  output logic [1:0] cmp_bd
);
  localparam int LANE_W = $clog2(CNT_W / 8);

  logic [NCH-1:0]            run_eff, cont, bf_c, bf_d, hit, peer_clr;
  logic                      sync;
  logic [7:0]                ctrl_q, mode_q;
  logic [NCH-1:0][7:0]       ch_rdata;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic [3:0]                ch_field;
  logic [2:0]                sel;
  logic [LANE_W-1:0]         lane;

  assign ch_field = bus_addr[7:4];
  assign sel      = bus_addr[LANE_W +: 3];
  assign lane     = bus_addr[LANE_W-1:0];

  oc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (bus_wr && bus_addr == ADDR_CTRL),
    .wr_mode (bus_wr && bus_addr == ADDR_MODE),
    .wdata   (bus_wdata),
    .hit     (hit),
    .run_eff (run_eff),
    .cont    (cont),
    .bf_c    (bf_c),
    .bf_d    (bf_d),
    .sync    (sync),
    .ctrl_q  (ctrl_q),
    .mode_q  (mode_q)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign peer_clr[c] = sync && hit[NCH-1-c];

      oc_channel #(.CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_eff[c]),
        .peer_clr (peer_clr[c]),
        .bf_c     (bf_c[c]),
        .bf_d     (bf_d[c]),
        .wr_en    (bus_wr && ch_field == 4'(c + 1)),
        .sel      (sel),
        .lane     (lane),
        .wdata    (bus_wdata),
        .rdata    (ch_rdata[c]),
        .hit      (hit[c]),
        .cnt      (cnt[c]),
        .cmp_ac   (cmp_ac[c]),
        .cmp_bd   (cmp_bd[c])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_CTRL)
      bus_rdata = ctrl_q;
    else if (bus_addr == ADDR_MODE)
      bus_rdata = mode_q;
    else
      for (int k = 0; k < NCH; k++)
        if (ch_field == 4'(k + 1)) bus_rdata = ch_rdata[k];
  end

  assert_sync_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && (|hit)) |=> (cnt[0] == '0 && cnt[1] == '0));
  assert_stop_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && !cont[0] && !sync) |=> (!run_eff[0] && ctrl_q[0] == 1'b0));
endmodule

// File: tb/dual_oc_timer_test.sv
module dual_oc_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] cmp_ac, cmp_bd;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_oc_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_ac(cmp_ac), .cmp_bd(cmp_bd)
  );

  // {addr, write data, expected readback}
  localparam int NVEC = 10;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'h0C, 8'hFC},   // R2 selects set, runs clear
    {8'h00, 8'h00, 8'hF0},   // R2 upper bits stay 1
    {8'h01, 8'hFF, 8'hFF},   // R2 mode all set
    {8'h01, 8'h00, 8'h0E},   // R2 mode bits 3:1 read 1
    {8'h01, 8'h50, 8'h5E},   // R2 role bits
    {8'h12, 8'h12, 8'h12},   // R11 A0 low
    {8'h13, 8'h34, 8'h34},   // R11 A0 high
    {8'h24, 8'h56, 8'h56},   // R11 B1 low
    {8'h29, 8'h9A, 8'h9A},   // R11 D1 high
    {8'h10, 8'h55, 8'h00}    // R11 counter is read-only
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 8'h01, d[15:8]);
  endtask

  task automatic do_reset();
    bus_wr = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // counts negedges until the selected pulse output is high
  task automatic wait_pulse(input int which, output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if ({cmp_bd, cmp_ac}[which]) return;
    end
    n = -1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    do_reset();

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 8'hFC);
    rd(8'h01, v); chk("R1 mode", v, 8'h0E);
    rd(8'h10, v); chk("R1 cnt0", v, 8'h00);
    rd(8'h12, v); chk("R1 A0", v, 8'hFF);
    rd(8'h29, v); chk("R1 D1", v, 8'hFF);
    rd(8'h40, v); chk("R11 unmapped", v, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      chk("R2/R11 vector", v, VEC[i][7:0]);
    end

    // R3 R4 R5 stop on match
    do_reset();
    wr16(8'h12, 16'd5);
    wr(8'h00, 8'h01);
    @(negedge clk); @(negedge clk);
    rd(8'h10, v); chk("R3 count", v, 8'd2);
    wait_pulse(0, n); chk("R4 match time", n, 4);
    rd(8'h10, v); chk("R4 wrap", v, 8'd0);
    rd(8'h00, v); chk("R5 run cleared", v, 8'hF0);
    @(negedge clk);
    chk("R4 one-cycle pulse", cmp_ac[0], 0);
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R3 held", v, 8'd0);

    // R7 hardware clear beats write
    do_reset();
    wr16(8'h12, 16'd2);
    wr(8'h00, 8'h01);
    @(negedge clk); @(negedge clk);
    wr(8'h00, 8'h01);
    chk("R7 pulse", cmp_ac[0], 1);
    rd(8'h00, v); chk("R7 run cleared", v, 8'hF0);

    // R6 continue mode on channel 1
    do_reset();
    wr16(8'h22, 16'd3);
    wr(8'h00, 8'h0A);
    wait_pulse(1, n); chk("R6 first period", n, 4);
    wait_pulse(1, n); chk("R6 second period", n, 4);
    rd(8'h00, v); chk("R6 still running", v, 8'hFA);
    chk("R6 other channel quiet", cmp_ac[0], 0);

    // R9 general compare on B, C, D
    do_reset();
    wr16(8'h14, 16'd2);
    wr16(8'h16, 16'd4);
    wr16(8'h18, 16'd5);
    wr(8'h00, 8'h01);
    wait_pulse(2, n); chk("R9 B match", n, 3);
    wait_pulse(0, n); chk("R9 C match", n, 2);
    wait_pulse(2, n); chk("R9 D match", n, 1);

    // R8 buffer transfer
    do_reset();
    wr(8'h01, 8'h30);
    rd(8'h01, v); chk("R2 buffer roles", v, 8'h3E);
    wr16(8'h12, 16'd3);
    wr16(8'h16, 16'd9);
    wr16(8'h14, 16'd1);
    wr16(8'h18, 16'h0044);
    wr(8'h00, 8'h05);
    wait_pulse(0, n); chk("R8 first period", n, 4);
    rd(8'h12, v); chk("R8 A loaded from C", v, 8'd9);
    rd(8'h14, v); chk("R8 B loaded from D", v, 8'h44);
    wait_pulse(0, n); chk("R8 new period", n, 10);

    // R10 sync mode
    do_reset();
    wr(8'h01, 8'h01);
    wr16(8'h12, 16'd4);
    wr16(8'h22, 16'd100);
    wr(8'h00, 8'h01);
    rd(8'h00, v); chk("R10 both run", v, 8'hF3);
    repeat (3) @(negedge clk);
    rd(8'h20, v); chk("R10 partner counts", v, 8'd3);
    wait_pulse(0, n); chk("R10 match time", n, 2);
    rd(8'h10, v); chk("R10 cnt0 cleared", v, 8'd0);
    rd(8'h20, v); chk("R10 cnt1 cleared", v, 8'd0);
    rd(8'h00, v); chk("R10 both stopped", v, 8'hF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule